// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block decides which NaN a two-input floating-point operation returns when one or both of its operands are NaNs. It sorts each operand into one of three classes: quiet NaN, signaling NaN, or not a NaN. It then applies one of three fixed operand-priority rule sets, which is chosen by a parameter. If the chosen operand is a signaling NaN, the block quiets it. The block also raises an invalid-operation flag whenever either operand is signaling.

A default-NaN control input overrides the selection and returns a configured canonical NaN pattern. A polarity parameter sets whether a set fraction MSB marks a quiet NaN or a signaling NaN. The operand format is parameterised, so the same block serves single and double precision.

The selection logic is purely combinational. The top level registers its result and flag, so both appear one clock after the operands are presented.

Top module: `nan_prop_sel`

## Requirements
- R1: With `SNAN_MSB_SET`=0, an operand whose exponent is all ones is a quiet NaN when fraction bit FRAC_W-1 is 1. It is a signaling NaN when that bit is 0 and the lower fraction bits are non-zero. An all-ones exponent with a zero fraction is an infinity, not a NaN.
- R2: With `SNAN_MSB_SET`=1, an all-ones exponent with fraction bit FRAC_W-1 set marks a signaling NaN. An all-ones exponent with that bit clear and a non-zero lower fraction marks a quiet NaN.
- R3: `invalid_out` is 1 exactly when either operand is a signaling NaN. This holds in default-NaN mode too.
- R4: When `dflt_mode` is 1, `nan_out` equals `DEFAULT_NAN`, whatever the operands are.
- R5: Rule set 0 takes the first match in this order: A if A is signaling, B if B is signaling, A if A is quiet, otherwise B.
- R6: Rule set 1 takes A when A is any NaN, otherwise B.
- R7: Rule set 2 works as follows. A signaling NaN paired with a quiet NaN gives the quiet one. A NaN paired with a non-NaN gives the NaN. Two NaNs of the same class give the one with the larger significand, as defined in R8.
- R8: The larger-significand test compares the two encodings with their sign bits removed. On a tie, A counts as larger when A's raw encoding is numerically smaller than B's, which means A is positive and B is negative.
- R9: A signaling result is quieted. With `SNAN_MSB_SET`=0 this is done by setting fraction bit FRAC_W-1 (bit 22 for single precision). With `SNAN_MSB_SET`=1 the result is replaced by `DEFAULT_NAN`.
- R10: When neither operand is a NaN and default-NaN mode is off, `nan_out` equals operand B unchanged.
- R11: `nan_out` and `invalid_out` are registered. They reflect the operands one rising clock edge after the operands are sampled, and they are zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 1+EXP_W+FRAC_W | First operand |
| op_b | input | 1+EXP_W+FRAC_W | Second operand |
| dflt_mode | input | 1 | Forces the default NaN result when high |
| nan_out | output | 1+EXP_W+FRAC_W | Selected, quieted NaN (registered) |
| invalid_out | output | 1 | Invalid-operation flag (registered) |

## Verification
Both the result and the invalid flag come from a single register stage, so each is due exactly one rising edge after the operands and mode are applied. The bench changes its stimulus on a falling edge and waits through one rising edge. It then samples on the following falling edge, away from the edge where the register updates. Four instances share the stimulus: three rule sets under the normal polarity, and one instance under the inverted polarity. Each comparison therefore checks all of them against the bench's own model in that same cycle.

// File: rtl/nan_sel_pkg.sv
package nan_sel_pkg;

  typedef enum int {
    RULE_SIG_FIRST = 0,
    RULE_A_FIRST   = 1,
    RULE_LARGER    = 2
  } rule_e;

  // Returns 1 to take operand B, 0 to take operand A.
  function automatic logic choose_b(input int rule,
                                    input logic aq, input logic as_,
                                    input logic bq, input logic bs,
                                    input logic a_larger);
    logic pick;
    case (rule)
      RULE_SIG_FIRST: begin
        if (as_)      pick = 1'b0;
        else if (bs)  pick = 1'b1;
        else if (aq)  pick = 1'b0;
        else          pick = 1'b1;
      end
      RULE_A_FIRST: begin
        pick = !(aq || as_);
      end
      default: begin
        if (as_) begin
          if (bs) pick = !a_larger;
          else    pick = bq;
        end else if (aq) begin
          if (bs || !bq) pick = 1'b0;
          else           pick = !a_larger;
        end else begin
          pick = 1'b1;
        end
      end
    endcase
    return pick;
  endfunction

endpackage

// File: rtl/nan_classify.sv
module nan_classify #(
  parameter int EXP_W        = 8,
  parameter int FRAC_W       = 23,
  parameter bit SNAN_MSB_SET = 1'b0,
  localparam int BODY_W      = EXP_W + FRAC_W
) (
  input  logic [BODY_W-1:0] body,
  output logic              is_qnan,
  output logic              is_snan
);
  logic exp_ones;
  logic frac_msb;
  logic frac_rest_nz;

  assign exp_ones     = &body[BODY_W-1:FRAC_W];
  assign frac_msb     = body[FRAC_W-1];
  assign frac_rest_nz = |body[FRAC_W-2:0];

  generate
    if (SNAN_MSB_SET) begin : g_inv
      assign is_snan = exp_ones && frac_msb;
      assign is_qnan = exp_ones && !frac_msb && frac_rest_nz;
    end else begin : g_norm
      assign is_qnan = exp_ones && frac_msb;
      assign is_snan = exp_ones && !frac_msb && frac_rest_nz;
    end
  endgenerate
endmodule

// File: rtl/nan_magcmp.sv
module nan_magcmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_larger
);
  logic [W-2:0] mag_a;
  logic [W-2:0] mag_b;

  assign mag_a = a[W-2:0];
  assign mag_b = b[W-2:0];

  always_comb begin
    if (mag_a != mag_b) a_larger = (mag_a > mag_b);
    else                a_larger = (a < b);
  end
endmodule

// File: rtl/nan_quiet.sv
module nan_quiet #(
  parameter int            W            = 32,
  parameter int            FRAC_W       = 23,
  parameter bit            SNAN_MSB_SET = 1'b0,
  parameter logic [W-1:0]  DEFAULT_NAN  = 32'h7FC00000
) (
  input  logic [W-1:0] val,
  input  logic         is_snan,
  output logic [W-1:0] quieted
);
  localparam logic [W-1:0] QUIET_MASK = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  generate
    if (SNAN_MSB_SET) begin : g_replace
      assign quieted = is_snan ? DEFAULT_NAN : val;
    end else begin : g_setbit
      assign quieted = is_snan ? (val | QUIET_MASK) : val;
    end
  endgenerate
endmodule

// File: rtl/nan_prop_sel.sv
module nan_prop_sel #(
  parameter int EXP_W        = 8,
  parameter int FRAC_W       = 23,
  parameter int RULE_SET     = 0,
  parameter bit SNAN_MSB_SET = 1'b0,
  parameter logic [EXP_W+FRAC_W:0] DEFAULT_NAN = 32'h7FC00000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  input  logic                    dflt_mode,
  output logic [EXP_W+FRAC_W:0]   nan_out,
  output logic                    invalid_out
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic         a_qnan, a_snan, b_qnan, b_snan;
  logic         a_larger;
  logic         pick_b;
  logic [W-1:0] a_quiet, b_quiet;
  logic [W-1:0] comb_res;
  logic         comb_inv;

  nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SNAN_MSB_SET(SNAN_MSB_SET)) u_cls_a (
    .body(op_a[W-2:0]), .is_qnan(a_qnan), .is_snan(a_snan));

  nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SNAN_MSB_SET(SNAN_MSB_SET)) u_cls_b (
    .body(op_b[W-2:0]), .is_qnan(b_qnan), .is_snan(b_snan));

  nan_magcmp #(.W(W)) u_cmp (.a(op_a), .b(op_b), .a_larger(a_larger));

  nan_quiet #(.W(W), .FRAC_W(FRAC_W), .SNAN_MSB_SET(SNAN_MSB_SET), .DEFAULT_NAN(DEFAULT_NAN)) u_q_a (
    .val(op_a), .is_snan(a_snan), .quieted(a_quiet));

  nan_quiet #(.W(W), .FRAC_W(FRAC_W), .SNAN_MSB_SET(SNAN_MSB_SET), .DEFAULT_NAN(DEFAULT_NAN)) u_q_b (
    .val(op_b), .is_snan(b_snan), .quieted(b_quiet));

  assign pick_b   = nan_sel_pkg::choose_b(RULE_SET, a_qnan, a_snan, b_qnan, b_snan, a_larger);
  assign comb_inv = a_snan || b_snan;
  assign comb_res = dflt_mode ? DEFAULT_NAN : (pick_b ? b_quiet : a_quiet);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nan_out     <= '0;
      invalid_out <= 1'b0;
    end else begin
      nan_out     <= comb_res;
      invalid_out <= comb_inv;
    end
  end
endmodule

// File: rtl/nan_prop_sel_chk.sv
module nan_prop_sel_chk #(
  parameter int           W            = 32,
  parameter int           FRAC_W       = 23,
  parameter bit           SNAN_MSB_SET = 1'b0,
  parameter logic [W-1:0] DEFAULT_NAN  = 32'h7FC00000
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_b,
  input logic         dflt_mode,
  input logic [W-1:0] nan_out,
  input logic         invalid_out,
  input logic         a_qnan,
  input logic         a_snan,
  input logic         b_qnan,
  input logic         b_snan
);
  logic out_exp_ones;
  logic out_is_snan;

  assign out_exp_ones = &nan_out[W-2:FRAC_W];
  assign out_is_snan  = SNAN_MSB_SET ? (out_exp_ones && nan_out[FRAC_W-1])
                                     : (out_exp_ones && !nan_out[FRAC_W-1] && (|nan_out[FRAC_W-2:0]));

  assert_dflt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(dflt_mode)) |-> (nan_out == DEFAULT_NAN));

  assert_invalid_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(a_snan || b_snan)) |-> invalid_out);

  assert_invalid_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(a_snan || b_snan)) |-> !invalid_out);

  assert_no_snan_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !out_is_snan);

  assert_pass_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!dflt_mode && !a_qnan && !a_snan && !b_qnan && !b_snan))
      |-> (nan_out == $past(op_b)));
endmodule

bind nan_prop_sel nan_prop_sel_chk #(
  .W(W), .FRAC_W(FRAC_W), .SNAN_MSB_SET(SNAN_MSB_SET), .DEFAULT_NAN(DEFAULT_NAN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_b(op_b), .dflt_mode(dflt_mode),
  .nan_out(nan_out), .invalid_out(invalid_out),
  .a_qnan(a_qnan), .a_snan(a_snan), .b_qnan(b_qnan), .b_snan(b_snan)
);

// File: tb/tb_nan_prop_sel.sv
module tb_nan_prop_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        dflt_mode = 1'b0;
  logic [31:0] res [4];
  logic        inv [4];

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] DN_NORM = 32'h7FC00000;
  localparam logic [31:0] DN_INV  = 32'h7FBFFFFF;

  always #4 clk = ~clk;

  nan_prop_sel #(.RULE_SET(0), .SNAN_MSB_SET(1'b0), .DEFAULT_NAN(DN_NORM)) dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .dflt_mode(dflt_mode),
    .nan_out(res[0]), .invalid_out(inv[0]));
  nan_prop_sel #(.RULE_SET(1), .SNAN_MSB_SET(1'b0), .DEFAULT_NAN(DN_NORM)) dut_r1 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .dflt_mode(dflt_mode),
    .nan_out(res[1]), .invalid_out(inv[1]));
  nan_prop_sel #(.RULE_SET(2), .SNAN_MSB_SET(1'b0), .DEFAULT_NAN(DN_NORM)) dut_r2 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .dflt_mode(dflt_mode),
    .nan_out(res[2]), .invalid_out(inv[2]));
  nan_prop_sel #(.RULE_SET(2), .SNAN_MSB_SET(1'b1), .DEFAULT_NAN(DN_INV)) dut_inv (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .dflt_mode(dflt_mode),
    .nan_out(res[3]), .invalid_out(inv[3]));

  // Per-instance configuration as the bench sees it.
  function automatic int rule_of(int i);
    return (i == 0) ? 0 : (i == 1) ? 1 : 2;
  endfunction
  function automatic bit pol_of(int i);
    return (i == 3);
  endfunction
  function automatic logic [31:0] dn_of(int i);
    return (i == 3) ? DN_INV : DN_NORM;
  endfunction
  function automatic string tag_of(int i);
    return (i == 0) ? "R5" : (i == 1) ? "R6" : (i == 2) ? "R7" : "R2";
  endfunction

  // Kind: 0 = not NaN, 1 = quiet, 2 = signaling.
  function automatic int kind(logic [31:0] v, bit pol);
    if (v[30:0] < 31'h7F800001) return 0;
    if (pol) return v[22] ? 2 : 1;
    return v[22] ? 1 : 2;
  endfunction

  function automatic bit a_bigger(logic [31:0] a, logic [31:0] b);
    if (a[30:0] > b[30:0]) return 1'b1;
    if (a[30:0] < b[30:0]) return 1'b0;
    return a < b;
  endfunction

  function automatic bit take_b(int rule, int ka, int kb, bit big);
    if (rule == 0) begin
      if (ka == 2) return 1'b0;
      if (kb == 2) return 1'b1;
      return (ka != 1);
    end
    if (rule == 1) return (ka == 0);
    if (ka == 0) return 1'b1;
    if (kb == 0) return 1'b0;
    if (ka != kb) return (kb == 1);
    return !big;
  endfunction

  function automatic logic [31:0] model(int i, logic [31:0] a, logic [31:0] b, logic m);
    logic [31:0] sel;
    if (m) return dn_of(i);
    sel = take_b(rule_of(i), kind(a, pol_of(i)), kind(b, pol_of(i)), a_bigger(a, b)) ? b : a;
    if (kind(sel, pol_of(i)) == 2) return pol_of(i) ? dn_of(i) : (sel | 32'h0040_0000);
    return sel;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // Apply stimulus on a falling edge; the registered result is due after the
  // next rising edge, so sample on the falling edge that follows it.
  task automatic apply(logic [31:0] a, logic [31:0] b, logic m);
    @(negedge clk);
    op_a = a; op_b = b; dflt_mode = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      chk("R11", "reset nan_out", res[i], 32'h0);
      chk("R11", "reset invalid", {31'b0, inv[i]}, 32'h0);
    end
  endtask

  task automatic t_sweep;
    logic [31:0] pool [5];
    pool[0] = 32'h3F800000;
    pool[1] = 32'hFF800000;
    pool[2] = 32'h7FC00005;
    pool[3] = 32'hFFA00003;
    pool[4] = 32'h7F800011;
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < 5; x++) begin
        for (int y = 0; y < 5; y++) begin
          apply(pool[x], pool[y], m[0]);
          for (int i = 0; i < 4; i++) begin
            chk(m[0] ? "R4" : tag_of(i), "sweep result", res[i], model(i, pool[x], pool[y], m[0]));
            chk("R3", "sweep invalid", {31'b0, inv[i]},
                {31'b0, (kind(pool[x], pol_of(i)) == 2) || (kind(pool[y], pol_of(i)) == 2)});
          end
        end
      end
    end
  endtask

  task automatic t_classify;
    apply(32'h7F800000, 32'h7FC00001, 1'b0);
    chk("R1", "infinity not NaN, rule1 takes B", res[1], 32'h7FC00001);
    chk("R1", "infinity not signaling", {31'b0, inv[1]}, 32'h0);
    apply(32'h7F800001, 32'h3F800000, 1'b0);
    chk("R1", "minimal signaling A taken", res[1], 32'h7FC00001);
    chk("R1", "minimal signaling raises invalid", {31'b0, inv[1]}, 32'h1);
  endtask

  task automatic t_quieting;
    apply(32'hFFA00003, 32'h3F800000, 1'b0);
    chk("R9", "normal polarity sets quiet bit", res[0], 32'hFFE00003);
    apply(32'h7FC00005, 32'h3F800000, 1'b0);
    chk("R9", "inverted polarity replaced by default", res[3], DN_INV);
    chk("R2", "inverted signaling raises invalid", {31'b0, inv[3]}, 32'h1);
  endtask

  task automatic t_tiebreak;
    apply(32'h7FC00001, 32'h7FC00009, 1'b0);
    chk("R8", "larger magnitude B wins", res[2], 32'h7FC00009);
    apply(32'hFFC00009, 32'h7FC00001, 1'b0);
    chk("R8", "sign ignored in magnitude", res[2], 32'hFFC00009);
    apply(32'hFFC00005, 32'h7FC00005, 1'b0);
    chk("R8", "tie, positive B wins", res[2], 32'h7FC00005);
    apply(32'h7FC00005, 32'hFFC00005, 1'b0);
    chk("R8", "tie, positive A wins", res[2], 32'h7FC00005);
    apply(32'hFFA00003, 32'h7FA00003, 1'b0);
    chk("R8", "tie of signaling pair, positive B quieted", res[2], 32'h7FE00003);
  endtask

  task automatic t_non_nan;
    apply(32'h3F800000, 32'hC0000000, 1'b0);
    for (int i = 0; i < 4; i++) begin
      chk("R10", "non-NaN pair returns B", res[i], 32'hC0000000);
      chk("R10", "non-NaN pair no invalid", {31'b0, inv[i]}, 32'h0);
    end
  endtask

  task automatic t_latency;
    apply(32'h3F800000, 32'h40000000, 1'b0);
    @(negedge clk);
    op_b = 32'h7FC00007;
    #1;
    chk("R11", "output holds before edge", res[0], 32'h40000000);
    @(posedge clk);
    @(negedge clk);
    chk("R11", "output updates after one edge", res[0], 32'h7FC00007);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sweep();
    t_classify();
    t_quieting();
    t_tiebreak();
    t_non_nan();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule